// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers a wide set of interrupt request lines, organised in groups of 32, and turns them into a single prioritised request for a processor. Every line passes through a two-flop synchroniser and lands in a per-group request register. Software can read that register to find out which line inside a group is asserted. Each group is reduced by an OR to one pending flag. That flag carries the priority level (one of four) and the vector offset that software has programmed for the group.

The processor supplies four per-level mask bits and a global mask bit. A pending group whose level is masked, or any maskable group while the global mask is set, takes no part in arbitration. Among the remaining groups the highest level wins, and a tie goes to the lowest group index. A separate non-maskable request overrides all of this. The result is registered and presented as a valid flag, a non-maskable flag, a 2-bit level and a 14-bit offset.

A small word-addressed register port gives read access to the request registers and read/write access to the per-group priority registers. Reads are combinational.

Top module: `grouped_irq_ctrl`

## Requirements
- R1: Line `32*g+i` is synchronised by two flops into bit `i` of the request register of group `g`, which is read at address `g`. A line set before a clock edge is visible in the read data after the second edge that follows.
- R2: Writes to a request register address (`0` to `NUM_GROUPS-1`) change nothing. The read data and the interrupt output stay the same.
- R3: The priority register of group `g` sits at address `NUM_GROUPS+g`. The level is in bits 31:30 and the offset is in bits 13:0. All other bits read zero. After reset the level is 0 and the offset is 0.
- R4: A group requests whenever any of its lines is set in its request register. It then offers its programmed level and offset. When no line and no non-maskable request is set, the output is not valid.
- R5: `levelMask[k]=1` removes every group programmed to level `k` from arbitration.
- R6: `globalMask=1` removes every maskable group from arbitration.
- R7: Among the unmasked requesting groups, the one with the highest level (3 above 0) wins.
- R8: When several unmasked groups share the highest level, the lowest group index wins.
- R9: A synchronised `nmiReq` wins over everything and ignores both masks. The output is then `intValid=1`, `intNmi=1`, `intLevel=0`, `intOffset=0`.
- R10: The output is registered. It changes at the first clock edge after a change of the request registers, the masks or a priority register. When it is not valid, all of its fields are zero.
- R11: While reset is asserted, the interrupt output is all zero and both synchroniser stages are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for sampling, registers and output |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_GROUPS*32 | Interrupt request lines, asynchronous |
| nmiReq | input | 1 | Non-maskable request, asynchronous |
| levelMask | input | 4 | Processor per-level mask, bit k blocks level k |
| globalMask | input | 1 | Processor global mask for all maskable groups |
| regAddr | input | ADDR_W | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| intValid | output | 1 | An interrupt is being offered |
| intNmi | output | 1 | The offered interrupt is the non-maskable one |
| intLevel | output | 2 | Level of the winning group |
| intOffset | output | 14 | Vector offset of the winning group |

## Verification
The assertions check on every cycle that the non-maskable flag follows the request input through exactly three register stages. They also check that a non-maskable or idle output carries zero fields, that a maskable winner never has a level that was masked in the previous cycle or arrived under the global mask, and that three quiet cycles on the inputs give an invalid output. Only the bench scenarios can show which group wins when levels differ or tie, that the offset comes from the right priority register, that writes to request addresses are ignored, and the exact edge at which a priority write or a mask change reaches the output.

// File: rtl/igc_pkg.sv
package igc_pkg;

  localparam int LINES_PER_GROUP = 32;
  localparam int LEVEL_W = 2;
  localparam int NUM_LEVELS = 1 << LEVEL_W;
  localparam int OFFSET_W = 14;
  localparam int DATA_W = 32;
  localparam int PAD_W = DATA_W - LEVEL_W - OFFSET_W;

  typedef struct packed {
    logic [LEVEL_W-1:0]  level;
    logic [OFFSET_W-1:0] offset;
  } groupPrio_t;

  typedef struct packed {
    logic                valid;
    logic                nmi;
    logic [LEVEL_W-1:0]  level;
    logic [OFFSET_W-1:0] offset;
  } intOut_t;

  typedef struct packed {
    logic readReq;
    logic readPrio;
    logic prioWr;
  } regStrobe_t;

endpackage

// File: rtl/igc_reg_ctrl.sv
module igc_reg_ctrl
  import igc_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int ADDR_W = $clog2(2 * NUM_GROUPS),
  parameter int GIDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobes,
  output logic [GIDX_W-1:0] grpIdx
);

  localparam int ADDR_SPAN = 2 * NUM_GROUPS;

  logic [31:0] addrWide;
  assign addrWide = 32'(regAddr);

  always_comb begin
    strobes = '0;
    grpIdx  = '0;
    if (addrWide < 32'(NUM_GROUPS)) begin
      strobes.readReq = 1'b1;
      grpIdx = GIDX_W'(addrWide);
    end else if (addrWide < 32'(ADDR_SPAN)) begin
      strobes.readPrio = 1'b1;
      strobes.prioWr   = regWrEn;
      grpIdx = GIDX_W'(addrWide - 32'(NUM_GROUPS));
    end
  end

endmodule

// File: rtl/igc_datapath.sv
module igc_datapath
  import igc_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int GIDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int NUM_LINES = NUM_GROUPS * LINES_PER_GROUP
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LINES-1:0]  irqIn,
  input  logic                  nmiReq,
  input  regStrobe_t            strobes,
  input  logic [GIDX_W-1:0]     grpIdx,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  output logic [NUM_GROUPS-1:0] grpReq,
  output groupPrio_t            grpPrio [NUM_GROUPS],
  output logic                  nmiSync
);

  logic [NUM_GROUPS-1:0][LINES_PER_GROUP-1:0] syncStage;
  logic [NUM_GROUPS-1:0][LINES_PER_GROUP-1:0] reqReg;
  logic nmiStage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiStage <= 1'b0;
      nmiSync  <= 1'b0;
    end else begin
      nmiStage <= nmiReq;
      nmiSync  <= nmiStage;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncStage[g] <= '0;
        reqReg[g]    <= '0;
      end else begin
        syncStage[g] <= irqIn[g*LINES_PER_GROUP +: LINES_PER_GROUP];
        reqReg[g]    <= syncStage[g];
      end
    end

    assign grpReq[g] = |reqReg[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        grpPrio[g] <= '0;
      end else if (strobes.prioWr && (grpIdx == GIDX_W'(g))) begin
        grpPrio[g].level  <= regWrData[DATA_W-1 -: LEVEL_W];
        grpPrio[g].offset <= regWrData[OFFSET_W-1:0];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grpIdx == GIDX_W'(g)) begin
        if (strobes.readReq) begin
          regRdData = DATA_W'(reqReg[g]);
        end else if (strobes.readPrio) begin
          regRdData = {grpPrio[g].level, {PAD_W{1'b0}}, grpPrio[g].offset};
        end
      end
    end
  end

endmodule

// File: rtl/igc_arbiter.sv
module igc_arbiter
  import igc_pkg::*;
#(
  parameter int NUM_GROUPS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_GROUPS-1:0] grpReq,
  input  groupPrio_t            grpPrio [NUM_GROUPS],
  input  logic                  nmiSync,
  input  logic [NUM_LEVELS-1:0] levelMask,
  input  logic                  globalMask,
  output intOut_t               intOut
);

  intOut_t nextOut;
  logic [NUM_GROUPS-1:0] grpValid;

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      grpValid[g] = grpReq[g] && !globalMask && !levelMask[grpPrio[g].level];
    end
  end

  always_comb begin
    nextOut = '0;
    if (nmiSync) begin
      nextOut.valid = 1'b1;
      nextOut.nmi   = 1'b1;
    end else begin
      // ascending scan keeps the lower index on equal level
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (grpValid[g] && (!nextOut.valid || (grpPrio[g].level > nextOut.level))) begin
          nextOut.valid  = 1'b1;
          nextOut.level  = grpPrio[g].level;
          nextOut.offset = grpPrio[g].offset;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intOut <= '0;
    end else begin
      intOut <= nextOut;
    end
  end

endmodule

// File: rtl/grouped_irq_ctrl.sv
module grouped_irq_ctrl
  import igc_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int NUM_LINES = NUM_GROUPS * 32,
  parameter int ADDR_W = $clog2(2 * NUM_GROUPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 nmiReq,
  input  logic [3:0]           levelMask,
  input  logic                 globalMask,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic                 intValid,
  output logic                 intNmi,
  output logic [1:0]           intLevel,
  output logic [13:0]          intOffset
);

  localparam int GIDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  regStrobe_t            strobes;
  logic [GIDX_W-1:0]     grpIdx;
  logic [NUM_GROUPS-1:0] grpReq;
  groupPrio_t            grpPrio [NUM_GROUPS];
  logic                  nmiSync;
  intOut_t               intOut;

  igc_reg_ctrl #(
    .NUM_GROUPS(NUM_GROUPS),
    .ADDR_W    (ADDR_W),
    .GIDX_W    (GIDX_W)
  ) u_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobes(strobes),
    .grpIdx (grpIdx)
  );

  igc_datapath #(
    .NUM_GROUPS(NUM_GROUPS),
    .GIDX_W    (GIDX_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .nmiReq   (nmiReq),
    .strobes  (strobes),
    .grpIdx   (grpIdx),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .grpReq   (grpReq),
    .grpPrio  (grpPrio),
    .nmiSync  (nmiSync)
  );

  igc_arbiter #(
    .NUM_GROUPS(NUM_GROUPS)
  ) u_arb (
    .clk       (clk),
    .rstN      (rstN),
    .grpReq    (grpReq),
    .grpPrio   (grpPrio),
    .nmiSync   (nmiSync),
    .levelMask (levelMask),
    .globalMask(globalMask),
    .intOut    (intOut)
  );

  assign intValid  = intOut.valid;
  assign intNmi    = intOut.nmi;
  assign intLevel  = intOut.level;
  assign intOffset = intOut.offset;

endmodule

// File: rtl/igc_checker.sv
module igc_checker #(
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] irqIn,
  input logic                 nmiReq,
  input logic [3:0]           levelMask,
  input logic                 globalMask,
  input logic                 intValid,
  input logic                 intNmi,
  input logic [1:0]           intLevel,
  input logic [13:0]          intOffset
);

  logic [1:0] sinceRst;
  logic [3:0] levelMaskD;
  logic       globalMaskD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst    <= '0;
      levelMaskD  <= '0;
      globalMaskD <= 1'b0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
      levelMaskD  <= levelMask;
      globalMaskD <= globalMask;
    end
  end

  // R9: non-maskable flag follows the request through three stages
  p_nmi_track_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (intNmi == $past(nmiReq, 3)));

  // R9: a non-maskable output carries fixed fields
  p_nmi_fields_r9: assert property (@(posedge clk) disable iff (!rstN)
    intNmi |-> (intValid && intLevel == 2'd0 && intOffset == 14'd0));

  // R10: an idle output is all zero
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !intValid |-> (!intNmi && intLevel == 2'd0 && intOffset == 14'd0));

  // R5: the winner's level was not masked when it was chosen
  p_level_unmasked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && intValid && !intNmi) |-> !levelMaskD[intLevel]);

  // R6: no maskable winner under the global mask
  p_global_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && globalMaskD) |-> (!intValid || intNmi));

  // R4: quiet inputs give an invalid output
  p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(irqIn, 3) == '0 && !$past(nmiReq, 3)) |-> !intValid);

endmodule

bind grouped_irq_ctrl igc_checker #(.NUM_LINES(NUM_LINES)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqIn     (irqIn),
  .nmiReq    (nmiReq),
  .levelMask (levelMask),
  .globalMask(globalMask),
  .intValid  (intValid),
  .intNmi    (intNmi),
  .intLevel  (intLevel),
  .intOffset (intOffset)
);

// File: tb/test_grouped_irq_ctrl.sv
module test_grouped_irq_ctrl;

  localparam int G  = 3;
  localparam int NL = G * 32;
  localparam int AW = $clog2(2 * G);

  logic          clk = 1'b0;
  logic          rstN;
  logic [NL-1:0] irqIn;
  logic          nmiReq;
  logic [3:0]    levelMask;
  logic          globalMask;
  logic [AW-1:0] regAddr;
  logic          regWrEn;
  logic [31:0]   regWrData;
  logic [31:0]   regRdData;
  logic          intValid;
  logic          intNmi;
  logic [1:0]    intLevel;
  logic [13:0]   intOffset;

  always #10 clk = ~clk;

  grouped_irq_ctrl #(.NUM_GROUPS(G)) i_grouped_irq_ctrl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .nmiReq(nmiReq),
    .levelMask(levelMask), .globalMask(globalMask),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .intValid(intValid), .intNmi(intNmi),
    .intLevel(intLevel), .intOffset(intOffset)
  );

  typedef struct {
    logic        v;
    logic        n;
    logic [1:0]  l;
    logic [13:0] o;
    string       tag;
  } exp_t;

  exp_t sbQ[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // monitor: compares each expected item with the outputs
  initial begin
    forever begin
      exp_t e;
      wait (sbQ.size() > 0);
      e = sbQ.pop_front();
      checks++;
      if ({intValid, intNmi, intLevel, intOffset} !== {e.v, e.n, e.l, e.o}) begin
        fails++;
        $display("FAIL %s: out v=%0b n=%0b l=%0d o=%h expected v=%0b n=%0b l=%0d o=%h",
                 e.tag, intValid, intNmi, intLevel, intOffset, e.v, e.n, e.l, e.o);
      end
    end
  end

  task automatic expectOut(input logic v, input logic n, input logic [1:0] l,
                           input logic [13:0] o, input string tag);
    exp_t e;
    e.v = v; e.n = n; e.l = l; e.o = o; e.tag = tag;
    sbQ.push_back(e);
    wait (sbQ.size() == 0);
  endtask

  task automatic checkRd(input int addr, input logic [31:0] exp, input string tag);
    regAddr = AW'(addr);
    #1;
    checks++;
    if (regRdData !== exp) begin
      fails++;
      $display("FAIL %s: read addr %0d got %h expected %h", tag, addr, regRdData, exp);
    end
  endtask

  task automatic regWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    regAddr = AW'(addr);
    regWrData = data;
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R10: watchdog expired, got no finish expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; irqIn = '0; nmiReq = 1'b0; levelMask = '0; globalMask = 1'b0;
    regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expectOut(0, 0, 0, 0, "R11 reset output");
    rstN = 1'b1;
    checkRd(G + 0, 32'h0, "R3 reset prio g0");
    checkRd(G + 2, 32'h0, "R3 reset prio g2");
    checkRd(1, 32'h0, "R11 reset request g1");

    // program priorities: g0 lvl1, g1 lvl2, g2 lvl2
    regWrite(G + 0, 32'h4000_0100);
    regWrite(G + 1, 32'h8000_0200);
    regWrite(G + 2, 32'h8000_0300);
    checkRd(G + 0, 32'h4000_0100, "R3 prio g0 readback");
    checkRd(G + 2, 32'h8000_0300, "R3 prio g2 readback");

    // R1 timing: line 5 (group 0 bit 5)
    @(negedge clk);
    irqIn[5] = 1'b1;
    checkRd(0, 32'h0, "R1 before first edge");
    @(posedge clk); @(negedge clk);
    checkRd(0, 32'h0, "R1 after one edge");
    @(posedge clk); @(negedge clk);
    checkRd(0, 32'h20, "R1 after two edges");
    @(posedge clk); @(negedge clk);
    expectOut(1, 0, 2'd1, 14'h100, "R4 single group request");

    // R7: line 40 is group 1 bit 8 at level 2
    irqIn[40] = 1'b1;
    settle();
    checkRd(1, 32'h100, "R1 group1 bit8");
    expectOut(1, 0, 2'd2, 14'h200, "R7 higher level wins");

    // R8: line 70 is group 2 bit 6, also level 2
    irqIn[70] = 1'b1;
    settle();
    checkRd(2, 32'h40, "R1 group2 bit6");
    expectOut(1, 0, 2'd2, 14'h200, "R8 tie lowest index");

    // R5: mask level 2
    levelMask = 4'b0100;
    settle();
    expectOut(1, 0, 2'd1, 14'h100, "R5 level mask");

    // R6: global mask
    globalMask = 1'b1;
    settle();
    expectOut(0, 0, 0, 0, "R6 global mask");

    // R9: NMI under all masks
    levelMask = 4'b1111;
    nmiReq = 1'b1;
    settle();
    expectOut(1, 1, 0, 0, "R9 nmi ignores masks");

    nmiReq = 1'b0; globalMask = 1'b0; levelMask = 4'b0000;
    settle();
    expectOut(1, 0, 2'd2, 14'h200, "R9 nmi released");

    // R2: writes to request address ignored
    regWrite(0, 32'hFFFF_FFFF);
    checkRd(0, 32'h20, "R2 request write ignored");
    @(posedge clk); @(negedge clk);
    expectOut(1, 0, 2'd2, 14'h200, "R2 output unchanged");

    // R10: mask change reaches output at the next edge
    levelMask = 4'b0100;
    #1;
    expectOut(1, 0, 2'd2, 14'h200, "R10 before edge");
    @(posedge clk); @(negedge clk);
    expectOut(1, 0, 2'd1, 14'h100, "R10 one edge after mask");

    // R10/R3: priority write, reserved bits read zero
    regWrite(G + 0, 32'hFFFF_FFFF);
    checkRd(G + 0, 32'hC000_3FFF, "R3 reserved bits zero");
    expectOut(1, 0, 2'd1, 14'h100, "R10 same edge as write");
    @(posedge clk); @(negedge clk);
    expectOut(1, 0, 2'd3, 14'h3FFF, "R10 edge after write");

    // R4: all lines cleared
    irqIn = '0;
    settle();
    expectOut(0, 0, 0, 0, "R4 no request idle");

    finished = 1;
    summary();
    $finish;
  end

endmodule